// File: doc/BRIEF.md
# Data-Processing ALU with Flags

This block is the 32-bit execute-stage arithmetic-logic unit of a small load/store processor core. Each issued operation brings a 4-bit command code, two operands, the current carry and overflow flags and a set-flags request. Sixteen commands are covered: bitwise operations, moves, addition and subtraction in forward and reverse order, with and without the incoming carry, and four compare/test forms that produce flags but never a result.

Operand selection is done upstream: the second operand is either a register value or an 8-bit unsigned immediate that has already been zero-extended to 32 bits. The condition flag register sits outside this block. The block returns the new flag values and a flag-write strobe, and that register captures them. All outputs are registered, so they appear one clock after the operation is issued. When nothing is issued, both write strobes stay low.

Top module: `exec_alu`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: One clock edge after an issued command, `res_o` holds that command's result. `res_we_o` is 1 for every command outside codes 1000..1011. With `issue_i` low, `res_we_o` and `flag_we_o` are 0 after the edge.
- R3: The test/compare codes TST=1000, TEQ=1001, CMP=1010 and CMN=1011 always give `res_we_o`=0.
- R4: `flag_we_o` is 1 only after an issued command with `setflags_i`=1. Otherwise it is 0, whatever the command.
- R5: The logical codes produce these results: AND=0000 gives A&B, EOR=0001 gives A^B, ORR=1100 gives A|B, MOV=1101 gives B, BIC=1110 gives A&~B, MVN=1111 gives ~B.
- R6: ADD=0100 gives A+B with C set to the carry out. SUB=0010 gives A-B and RSB=0011 gives B-A, with C set to NOT borrow (1 when the minuend is unsigned at least the subtrahend).
- R7: ADC=0101 gives A+B+carry_i. SBC=0110 gives A-B-(NOT carry_i) and RSC=0111 gives B-A-(NOT carry_i). For all three, C is the carry out, or NOT borrow for the subtracting forms.
- R8: For every arithmetic command, V is 1 exactly when the signed 32-bit result overflows.
- R9: The flags leave on `nzcv_o` with N at bit 3, Z at bit 2, C at bit 1 and V at bit 0. N equals result bit 31 and Z is 1 when the result is zero.
- R10: For logical commands (codes 0000, 0001, 1000, 1001, 1100..1111), C and V repeat `carry_i` and `ovf_i`.
- R11: TST, TEQ, CMP and CMN produce the same flags and the same `res_o` value as AND, EOR, SUB and ADD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An operation is presented this cycle |
| cmd_i | input | 4 | Command code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (register or zero-extended immediate) |
| carry_i | input | 1 | Current carry flag |
| ovf_i | input | 1 | Current overflow flag |
| setflags_i | input | 1 | Request to update the flags |
| res_o | output | 32 | Registered result |
| res_we_o | output | 1 | Destination register write enable |
| nzcv_o | output | 4 | New flags {N,Z,C,V} |
| flag_we_o | output | 1 | Flag register write enable |

## Verification
The assertions assume that `cmd_i`, `carry_i`, `ovf_i` and `setflags_i` are valid whenever `issue_i` is high. They also assume that the flag outputs are only used in a cycle where `flag_we_o` is set. The bench changes inputs only on the falling edge, keeps `issue_i` defined throughout, and drops it between operations so that idle cycles are exercised. A scoreboard checks result data only for issued commands and checks both strobes on every cycle.

// File: rtl/exec_alu_pkg.sv
package exec_alu_pkg;

    typedef enum logic [3:0] {
        CMD_AND = 4'h0, CMD_EOR = 4'h1, CMD_SUB = 4'h2, CMD_RSB = 4'h3,
        CMD_ADD = 4'h4, CMD_ADC = 4'h5, CMD_SBC = 4'h6, CMD_RSC = 4'h7,
        CMD_TST = 4'h8, CMD_TEQ = 4'h9, CMD_CMP = 4'hA, CMD_CMN = 4'hB,
        CMD_ORR = 4'hC, CMD_MOV = 4'hD, CMD_BIC = 4'hE, CMD_MVN = 4'hF
    } alu_cmd_e;

    typedef enum logic [2:0] {
        LOGIC_AND  = 3'd0,
        LOGIC_XOR  = 3'd1,
        LOGIC_OR   = 3'd2,
        LOGIC_PASS = 3'd3,
        LOGIC_CLR  = 3'd4,
        LOGIC_INV  = 3'd5
    } logic_fn_e;

    typedef enum logic [1:0] {
        CIN_ZERO  = 2'd0,
        CIN_ONE   = 2'd1,
        CIN_FLAG  = 2'd2
    } cin_mode_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    // Commands that go through the adder
    function automatic logic cmd_is_arith(input logic [3:0] cmd);
        case (cmd)
            4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB: return 1'b1;
            default:                                         return 1'b0;
        endcase
    endfunction

    // Test/compare group only updates flags
    function automatic logic cmd_writes_result(input logic [3:0] cmd);
        return cmd[3:2] != 2'b10;
    endfunction

endpackage

// File: rtl/exec_logic.sv
module exec_logic
    import exec_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic_fn_e          fn_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic [WIDTH-1:0]   y_o
);

    always_comb begin
        case (fn_i)
            LOGIC_AND:  y_o = a_i & b_i;
            LOGIC_XOR:  y_o = a_i ^ b_i;
            LOGIC_OR:   y_o = a_i | b_i;
            LOGIC_PASS: y_o = b_i;
            LOGIC_CLR:  y_o = a_i & ~b_i;
            LOGIC_INV:  y_o = ~b_i;
            default:    y_o = '0;
        endcase
    end

endmodule

// File: rtl/exec_adder.sv
module exec_adder
    import exec_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic               swap_i,
    input  logic               invert_i,
    input  cin_mode_e          cin_mode_i,
    input  logic               carry_flag_i,
    output logic [WIDTH-1:0]   sum_o,
    output logic               cout_o,
    output logic               ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] x_op;
    logic [WIDTH-1:0] y_raw;
    logic [WIDTH-1:0] y_op;
    logic             cin;
    logic [WIDTH:0]   wide;

    always_comb begin
        x_op  = swap_i ? b_i : a_i;
        y_raw = swap_i ? a_i : b_i;
        y_op  = invert_i ? ~y_raw : y_raw;
        case (cin_mode_i)
            CIN_ONE:  cin = 1'b1;
            CIN_FLAG: cin = carry_flag_i;
            default:  cin = 1'b0;
        endcase
        wide   = {1'b0, x_op} + {1'b0, y_op} + {{WIDTH{1'b0}}, cin};
        sum_o  = wide[MSB:0];
        cout_o = wide[WIDTH];
        ovf_o  = (x_op[MSB] == y_op[MSB]) && (wide[MSB] != x_op[MSB]);
    end

endmodule

// File: rtl/exec_flags.sv
module exec_flags
    import exec_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   result_i,
    input  logic               arith_i,
    input  logic               add_c_i,
    input  logic               add_v_i,
    input  logic               carry_i,
    input  logic               ovf_i,
    output logic [3:0]         nzcv_o
);

    always_comb begin
        nzcv_o         = '0;
        nzcv_o[FLAG_N] = result_i[WIDTH-1];
        nzcv_o[FLAG_Z] = (result_i == '0);
        nzcv_o[FLAG_C] = arith_i ? add_c_i : carry_i;
        nzcv_o[FLAG_V] = arith_i ? add_v_i : ovf_i;
    end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import exec_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_i,
    input  logic [3:0]         cmd_i,
    input  logic [WIDTH-1:0]   opa_i,
    input  logic [WIDTH-1:0]   opb_i,
    input  logic               carry_i,
    input  logic               ovf_i,
    input  logic               setflags_i,
    output logic [WIDTH-1:0]   res_o,
    output logic               res_we_o,
    output logic [3:0]         nzcv_o,
    output logic               flag_we_o
);

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             res_we;
        logic [3:0]       nzcv;
        logic             flag_we;
    } stage_t;

    stage_t st_d, st_q;

    logic             arith;
    logic             swap;
    logic             invert;
    cin_mode_e        cin_mode;
    logic_fn_e        lfn;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] add_y;
    logic             add_c;
    logic             add_v;
    logic [WIDTH-1:0] result;
    logic [3:0]       flags;

    // Command decode
    always_comb begin
        arith    = cmd_is_arith(cmd_i);
        swap     = 1'b0;
        invert   = 1'b0;
        cin_mode = CIN_ZERO;
        lfn      = LOGIC_AND;
        case (alu_cmd_e'(cmd_i))
            CMD_SUB, CMD_CMP: begin invert = 1'b1; cin_mode = CIN_ONE; end
            CMD_RSB:          begin swap = 1'b1; invert = 1'b1; cin_mode = CIN_ONE; end
            CMD_ADD, CMD_CMN: cin_mode = CIN_ZERO;
            CMD_ADC:          cin_mode = CIN_FLAG;
            CMD_SBC:          begin invert = 1'b1; cin_mode = CIN_FLAG; end
            CMD_RSC:          begin swap = 1'b1; invert = 1'b1; cin_mode = CIN_FLAG; end
            CMD_AND, CMD_TST: lfn = LOGIC_AND;
            CMD_EOR, CMD_TEQ: lfn = LOGIC_XOR;
            CMD_ORR:          lfn = LOGIC_OR;
            CMD_MOV:          lfn = LOGIC_PASS;
            CMD_BIC:          lfn = LOGIC_CLR;
            CMD_MVN:          lfn = LOGIC_INV;
            default:          lfn = LOGIC_AND;
        endcase
    end

    exec_logic #(.WIDTH(WIDTH)) u_logic (
        .fn_i (lfn),
        .a_i  (opa_i),
        .b_i  (opb_i),
        .y_o  (logic_y)
    );

    exec_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i          (opa_i),
        .b_i          (opb_i),
        .swap_i       (swap),
        .invert_i     (invert),
        .cin_mode_i   (cin_mode),
        .carry_flag_i (carry_i),
        .sum_o        (add_y),
        .cout_o       (add_c),
        .ovf_o        (add_v)
    );

    assign result = arith ? add_y : logic_y;

    exec_flags #(.WIDTH(WIDTH)) u_flags (
        .result_i (result),
        .arith_i  (arith),
        .add_c_i  (add_c),
        .add_v_i  (add_v),
        .carry_i  (carry_i),
        .ovf_i    (ovf_i),
        .nzcv_o   (flags)
    );

    always_comb begin
        st_d         = st_q;
        st_d.res_we  = 1'b0;
        st_d.flag_we = 1'b0;
        if (issue_i) begin
            st_d.res     = result;
            st_d.nzcv    = flags;
            st_d.res_we  = cmd_writes_result(cmd_i);
            st_d.flag_we = setflags_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o     = st_q.res;
    assign res_we_o  = st_q.res_we;
    assign nzcv_o    = st_q.nzcv;
    assign flag_we_o = st_q.flag_we;

    // R2: a writing command is followed by a result write
    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && cmd_i[3:2] != 2'b10) |=> res_we_o);

    // R3: test/compare group never writes the destination
    p_test_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && cmd_i[3:2] == 2'b10) |=> !res_we_o);

    // R4: no flag write without an issued set-flags request
    p_flag_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_i || !setflags_i) |=> !flag_we_o);

    // R9: N and Z agree with the registered result
    p_nz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> (nzcv_o[FLAG_N] == res_o[WIDTH-1]) &&
                      (nzcv_o[FLAG_Z] == (res_o == '0)));

    // R10: logical commands carry C and V through
    p_keep_cv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && setflags_i && !cmd_is_arith(cmd_i)) |=>
        (nzcv_o[FLAG_C] == $past(carry_i)) && (nzcv_o[FLAG_V] == $past(ovf_i)));

    // R1: reset clears the outputs
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0) && !res_we_o && (nzcv_o == '0) && !flag_we_o);

endmodule

// File: tb/exec_alu_test.sv
module exec_alu_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [3:0]  cmd_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        carry_i = 1'b0;
    logic        ovf_i = 1'b0;
    logic        setflags_i = 1'b0;
    logic [31:0] res_o;
    logic        res_we_o;
    logic [3:0]  nzcv_o;
    logic        flag_we_o;

    int checks = 0;
    int fails = 0;

    typedef struct {
        string       tag;
        logic        chk_data;
        logic [31:0] res;
        logic        we;
        logic [3:0]  f;
        logic        fwe;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    exec_alu uut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .cmd_i(cmd_i),
        .opa_i(opa_i), .opb_i(opb_i), .carry_i(carry_i), .ovf_i(ovf_i),
        .setflags_i(setflags_i), .res_o(res_o), .res_we_o(res_we_o),
        .nzcv_o(nzcv_o), .flag_we_o(flag_we_o)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Driver: presents one operation and pushes its expected outcome
    task automatic op(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                      input logic ci, input logic vi, input logic s, input string tag);
        exp_t   e;
        logic [31:0] r;
        logic [32:0] ua, ub;
        longint sa, sb_v, sres;
        int     bor;
        logic   cf, vf;
        ua = {1'b0, a};
        ub = {1'b0, b};
        sa = longint'($signed(a));
        sb_v = longint'($signed(b));
        bor = ci ? 0 : 1;
        cf = ci;
        vf = vi;
        sres = 0;
        case (c)
            4'h0, 4'h8: r = a & b;
            4'h1, 4'h9: r = a ^ b;
            4'hC:       r = a | b;
            4'hD:       r = b;
            4'hE:       r = a & ~b;
            4'hF:       r = ~b;
            4'h4, 4'hB: begin r = a + b; cf = (ua + ub) > 33'h0FFFFFFFF; sres = sa + sb_v; end
            4'h5: begin r = a + b + {31'd0, ci}; cf = (ua + ub + {32'd0, ci}) > 33'h0FFFFFFFF;
                        sres = sa + sb_v + (ci ? 1 : 0); end
            4'h2, 4'hA: begin r = a - b; cf = ua >= ub; sres = sa - sb_v; end
            4'h3: begin r = b - a; cf = ub >= ua; sres = sb_v - sa; end
            4'h6: begin r = a - b - 32'(bor); cf = ua >= ub + 33'(bor); sres = sa - sb_v - bor; end
            default: begin r = b - a - 32'(bor); cf = ub >= ua + 33'(bor); sres = sb_v - sa - bor; end
        endcase
        if (c inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB})
            vf = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
        e.tag = tag;
        e.chk_data = 1'b1;
        e.res = r;
        e.we = (c[3:2] != 2'b10);
        e.f = {r[31], (r == 32'd0), cf, vf};
        e.fwe = s;
        @(negedge clk);
        issue_i = 1'b1; cmd_i = c; opa_i = a; opb_i = b;
        carry_i = ci; ovf_i = vi; setflags_i = s;
        sb.push_back(e);
    endtask

    task automatic idle(input logic [3:0] c, input logic s, input string tag);
        exp_t e;
        e.tag = tag; e.chk_data = 1'b0; e.res = '0; e.we = 1'b0; e.f = '0; e.fwe = 1'b0;
        @(negedge clk);
        issue_i = 1'b0; cmd_i = c; setflags_i = s;
        opa_i = 32'h1234_5678; opb_i = 32'h1;
        sb.push_back(e);
    endtask

    // Monitor: compares each result just after the edge that registers it
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (res_we_o !== e.we || flag_we_o !== e.fwe ||
                (e.chk_data && (res_o !== e.res || nzcv_o !== e.f))) begin
                fails++;
                $display("FAIL %s: actual res=%h we=%b nzcv=%b fwe=%b expected res=%h we=%b nzcv=%b fwe=%b (data %b)",
                         e.tag, res_o, res_we_o, nzcv_o, flag_we_o, e.res, e.we, e.f, e.fwe, e.chk_data);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2: watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'h0, 4'h1, 4'hC, 4'hD, 4'hE, 4'hF: return "R5";
            4'h2, 4'h3, 4'h4:                   return "R6";
            4'h5, 4'h6, 4'h7:                   return "R7";
            default:                            return "R11";
        endcase
    endfunction

    initial begin
        // R1: outputs held at zero in reset, even with an operation presented
        issue_i = 1'b1; cmd_i = 4'h4; opa_i = 32'hFFFF_FFFF; opb_i = 32'h1; setflags_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (res_o !== 32'd0 || res_we_o !== 1'b0 || nzcv_o !== 4'd0 || flag_we_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: actual res=%h we=%b nzcv=%b fwe=%b expected all zero",
                     res_o, res_we_o, nzcv_o, flag_we_o);
        end
        issue_i = 1'b0;
        rst_n = 1'b1;

        // R5 logical results
        op(4'h0, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 1'b0, 1'b1, "R5");
        op(4'h1, 32'hAAAA_5555, 32'hFFFF_0000, 1'b1, 1'b1, 1'b1, "R5");
        op(4'hC, 32'h0000_00F0, 32'h0000_000F, 1'b0, 1'b1, 1'b1, "R5");
        op(4'hD, 32'hDEAD_BEEF, 32'h0000_00A5, 1'b1, 1'b0, 1'b1, "R5");
        op(4'hE, 32'hFFFF_FFFF, 32'h0000_00FF, 1'b0, 1'b0, 1'b1, "R5");
        op(4'hF, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, "R5");
        // R10: logical keeps C and V, zero result sets Z (R9)
        op(4'h0, 32'h5555_5555, 32'hAAAA_AAAA, 1'b1, 1'b1, 1'b1, "R10");
        op(4'h1, 32'h8000_0000, 32'h0, 1'b0, 1'b1, 1'b1, "R9");
        // R6 basic arithmetic and carry / not-borrow
        op(4'h4, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b1, "R6");
        op(4'h2, 32'h0, 32'h1, 1'b1, 1'b0, 1'b1, "R6");
        op(4'h2, 32'h5, 32'h5, 1'b0, 1'b0, 1'b1, "R6");
        op(4'h3, 32'h10, 32'h3, 1'b0, 1'b0, 1'b1, "R6");
        op(4'h3, 32'h3, 32'h10, 1'b0, 1'b0, 1'b1, "R6");
        // R8 signed overflow edges
        op(4'h4, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b1, "R8");
        op(4'h2, 32'h8000_0000, 32'h1, 1'b0, 1'b0, 1'b1, "R8");
        op(4'h3, 32'h1, 32'h8000_0000, 1'b0, 1'b0, 1'b1, "R8");
        // R7 carry variants, both carry values
        op(4'h5, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, 1'b1, "R7");
        op(4'h5, 32'h7FFF_FFFF, 32'h0, 1'b1, 1'b0, 1'b1, "R7");
        op(4'h6, 32'h5, 32'h5, 1'b0, 1'b0, 1'b1, "R7");
        op(4'h6, 32'h5, 32'h5, 1'b1, 1'b0, 1'b1, "R7");
        op(4'h7, 32'h2, 32'h9, 1'b0, 1'b1, 1'b1, "R7");
        op(4'h7, 32'h9, 32'h9, 1'b0, 1'b0, 1'b1, "R7");
        // R3 / R11 compare and test forms
        op(4'h8, 32'hFF00, 32'h00FF, 1'b1, 1'b0, 1'b1, "R3");
        op(4'h9, 32'h8000_0001, 32'h1, 1'b0, 1'b1, 1'b1, "R11");
        op(4'hA, 32'h7, 32'h9, 1'b1, 1'b1, 1'b1, "R11");
        op(4'hB, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b1, "R11");
        // R4: no set-flags request means no flag write
        op(4'h4, 32'h1, 32'h2, 1'b0, 1'b0, 1'b0, "R4");
        op(4'hA, 32'h3, 32'h3, 1'b0, 1'b0, 1'b0, "R4");
        // R2: idle cycles write nothing
        idle(4'h4, 1'b1, "R2");
        idle(4'hA, 1'b1, "R2");
        op(4'hD, 32'h0, 32'h0000_0080, 1'b0, 1'b0, 1'b0, "R2");
        idle(4'h0, 1'b0, "R2");

        // Mixed sweep over every command with varied operands
        for (int i = 0; i < 400; i++) begin
            logic [3:0]  c;
            logic [31:0] a, b;
            c = 4'(i % 16);
            a = $urandom();
            b = (i % 3 == 0) ? {24'd0, 8'($urandom())} : $urandom();
            if (i % 7 == 0) b = a;
            if (i % 11 == 0) idle(c, 1'b1, "R2");
            op(c, a, b, 1'($urandom()), 1'($urandom()), 1'($urandom()), tag_of(c));
        end

        idle(4'h0, 1'b0, "R2");
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        summary();
        $finish;
    end

endmodule